// File: doc/BRIEF.md
# Paged NIC Host Register File

This block is the byte-wide host register interface of a simple Ethernet controller. The host reaches it through sixteen port offsets. Offset 0 is always the command register. Every other offset is banked into pages by the two top bits of that command register. Some offsets select one register when written and another when read. The block holds these registers:

- the ring-buffer pointers (start, stop, boundary and current page);
- the transmit start page and the 16-bit transmit byte count;
- the 16-bit remote-DMA start address and the 16-bit remote-DMA byte count;
- the receive and data configuration bytes;
- six station-address bytes and eight multicast-filter bytes;
- an interrupt status register and an interrupt mask.

One level-sensitive interrupt output leaves the block.

Other blocks sit around it. A transmitter takes a one-cycle launch pulse together with the start page and byte count. A remote-DMA engine is told its direction while a transfer is pending, and it reports completion through the status-event input. The receiver and other engines also raise their status bits through that input. Register accesses use a synchronous write strobe and a registered read. Reset is synchronous and active high.

The control path is a small state machine with three states:

- `ST_STOPPED` is entered at reset and on any command written with the stop bit set.
- `ST_RUNNING` is entered on a command with stop clear that does not start a non-empty remote DMA. It is also entered from `ST_RDMA` when the DMA-complete event arrives.
- `ST_RDMA` is entered on a command with stop clear that requests a remote read or a remote write while the remote count is nonzero.

Top module: `nic_pagereg`

## Requirements
- R1: After reset the status register (page 0, offset 7) reads 0x80 and the command register reads 0x21. `irq`, `tx_start` and `rdma_req` are low.
- R2: Offset 0 reads and writes the command register from any page. Any other offset selects register index {cmd[7:6], offset}. Page 1 offsets 1–6 hold the station-address bytes, offset 7 the current page, and offsets 8–15 the multicast bytes. Each of these reads back as written. A page-0 register at the same offset is not disturbed.
- R3: On page 0 the read and write views differ. Writes to offsets 1 and 2 set ring start and ring stop, and these read back only through page 2, offsets 1 and 2. Offsets 10 and 11 are written as the remote count (low, high) but read 0x50 and 0x43. Offsets 8 and 9 hold the remote start address (low, high) and read it back. Offset 3 (boundary) reads back as written.
- R4: Every index not listed in R2, R3, R6 or R9 reads 0, including all of page 3.
- R5: `irq` is high exactly when (status AND mask) is nonzero in bits 6:0. The mask is written at page 0, offset 15. Status bit 7 never raises `irq`.
- R6: A write to page 0, offset 7 clears each status bit 6:0 whose data bit is 1, and it leaves bit 7 unchanged. A bit of `stat_set` that is high in the same cycle wins over the clear. `stat_set` bits 6:0 set status bits 6:0.
- R7: Any command write with bit 0 (stop) clear clears status bit 7.
- R8: A command write with stop clear and with bit 3 (remote read) or bit 4 (remote write) set, while the remote count is 0, sets status bit 6 at once. With a nonzero count it does not set bit 6.
- R9: A command write with bit 2 (transmit) set and stop clear has four effects. Page 0, offset 4 reads 0x01. Status bit 1 is set. `tx_start` is high for the single cycle after the write, with `tx_page` and `tx_count` taken from the transmit start page and count. The command reads back with bit 2 cleared. With stop set, no transmit occurs and the command is stored unchanged.
- R10: `rdma_req` is 2'b01 for a remote read and 2'b10 for a remote write while in `ST_RDMA`, and 2'b00 otherwise. `ST_RDMA` exits to `ST_RUNNING` on `stat_set[6]`, or on a stop-clear command that requests neither remote read nor remote write. Any command with stop set moves to `ST_STOPPED`.
- R11: `rx_cfg` and `data_cfg` show the last bytes written to page 0, offsets 12 and 14. `rdma_addr` and `rdma_count` show the remote start address and the remote count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears after the next edge |
| reg_addr | input | 4 | Port offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| stat_set | input | 7 | Status-set events from other engines; bit 6 is remote-DMA complete |
| irq | output | 1 | Level interrupt |
| tx_start | output | 1 | One-cycle transmit launch pulse |
| tx_page | output | 8 | Transmit start page captured at launch |
| tx_count | output | 16 | Transmit byte count captured at launch |
| rdma_req | output | 2 | Pending remote DMA: 01 read, 10 write |
| rdma_addr | output | 16 | Remote start address |
| rdma_count | output | 16 | Remote byte count |
| rx_cfg | output | 8 | Receive configuration byte |
| data_cfg | output | 8 | Data configuration byte |

## Verification
The bench builds the block with its default parameters. These give eight-bit data, four address bits, two page bits, six station bytes and eight multicast bytes, so all four pages and every mapped index can be reached.

Seeded random writes and reads spread across all pages. They compare each read against a bench model of the banked map, and they expose split read/write views and aliasing between pages. Directed cases cover:

- the zero-count remote-DMA command;
- a status set and clear falling in the same cycle;
- the never-interrupting reset bit;
- the transmit pulse timing;
- every transition of the state machine.

// File: rtl/nic_pagereg_pkg.sv
package nic_pagereg_pkg;

    // control state of the command path
    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_RDMA    = 2'd2
    } ctl_state_e;

    // command bit positions
    localparam int CB_STOP  = 0;
    localparam int CB_TX    = 2;
    localparam int CB_RRD   = 3;
    localparam int CB_RWR   = 4;

    // status bit positions
    localparam int SB_TXOK  = 1;
    localparam int SB_RDC   = 6;
    localparam int SB_RST   = 7;

endpackage

// File: rtl/nic_irq_unit.sv
module nic_irq_unit #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          isr_we,
    input  logic          imr_we,
    input  logic [DW-2:0] wdata,
    input  logic          clr_rst_bit,
    input  logic [DW-2:0] set_evt,
    output logic [DW-1:0] isr_q,
    output logic          irq_o
);
    localparam int LW = DW - 1;

    logic [LW-1:0] imr_q;
    logic [LW-1:0] clr_mask;
    logic [DW-1:0] isr_n;

    always_comb begin
        clr_mask = isr_we ? wdata : '0;
        isr_n[LW-1:0] = (isr_q[LW-1:0] & ~clr_mask) | set_evt;
        isr_n[DW-1]   = clr_rst_bit ? 1'b0 : isr_q[DW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= DW'(1) << (DW - 1);
            imr_q <= '0;
        end else begin
            isr_q <= isr_n;
            if (imr_we) imr_q <= wdata;
        end
    end

    assign irq_o = |(isr_q[LW-1:0] & imr_q);

    // R1 R6
    rst_bit_norise_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(isr_q[DW-1]));

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (isr_we && set_evt == '0) |=> ((isr_q[LW-1:0] & $past(wdata)) == '0));

endmodule

// File: rtl/nic_cmd_ctl.sv
module nic_cmd_ctl
    import nic_pagereg_pkg::*;
#(
    parameter int          DW      = 8,
    parameter logic [DW-1:0] CMD_RST = 8'h21
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_we,
    input  logic [DW-1:0]   wdata,
    input  logic            rcnt_zero,
    input  logic            dma_done,
    input  logic [DW-1:0]   tpsr,
    input  logic [2*DW-1:0] tcnt,
    output logic [DW-1:0]   cmd_q,
    output logic [DW-1:0]   tsr_q,
    output logic            clr_rst_bit,
    output logic            rdc_now,
    output logic            txok_now,
    output logic            tx_fire_q,
    output logic [DW-1:0]   tx_page_q,
    output logic [2*DW-1:0] tx_count_q,
    output logic [1:0]      rdma_req
);
    ctl_state_e st_q, st_n, cmd_target;
    logic       start_ok;
    logic       dma_ask;
    logic [1:0] dir_q;

    // command decode
    always_comb begin
        start_ok    = cmd_we && !wdata[CB_STOP];
        dma_ask     = wdata[CB_RRD] | wdata[CB_RWR];
        clr_rst_bit = start_ok;
        rdc_now     = start_ok && dma_ask && rcnt_zero;
        txok_now    = start_ok && wdata[CB_TX];
        if (wdata[CB_STOP])              cmd_target = ST_STOPPED;
        else if (dma_ask && !rcnt_zero)  cmd_target = ST_RDMA;
        else                             cmd_target = ST_RUNNING;
    end

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_STOPPED: if (cmd_we) st_n = cmd_target;
            ST_RUNNING: if (cmd_we) st_n = cmd_target;
            ST_RDMA: begin
                if (cmd_we)        st_n = cmd_target;
                else if (dma_done) st_n = ST_RUNNING;
            end
            default: st_n = ST_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_STOPPED;
        else     st_q <= st_n;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= CMD_RST;
            tsr_q      <= '0;
            tx_fire_q  <= 1'b0;
            tx_page_q  <= '0;
            tx_count_q <= '0;
            dir_q      <= 2'b00;
        end else begin
            tx_fire_q <= txok_now;
            if (cmd_we) begin
                cmd_q <= wdata;
                if (start_ok) cmd_q[CB_TX] <= 1'b0;
                if (cmd_target == ST_RDMA)
                    dir_q <= {wdata[CB_RWR], ~wdata[CB_RWR]};
            end
            if (txok_now) begin
                tsr_q      <= DW'(1);
                tx_page_q  <= tpsr;
                tx_count_q <= tcnt;
            end
        end
    end

    assign rdma_req = (st_q == ST_RDMA) ? dir_q : 2'b00;

    // R10
    rdma_running_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RDMA) |-> !cmd_q[CB_STOP]);

endmodule

// File: rtl/nic_reg_bank.sv
module nic_reg_bank #(
    parameter int            DW      = 8,
    parameter int            AW      = 4,
    parameter int            PGW     = 2,
    parameter int            PHYS_N  = 6,
    parameter int            MCAST_N = 8,
    parameter logic [DW-1:0] ID_LO   = 8'h50,
    parameter logic [DW-1:0] ID_HI   = 8'h43
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic            reg_re,
    input  logic [AW-1:0]   off,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   cmd_q,
    input  logic [DW-1:0]   isr_q,
    input  logic [DW-1:0]   tsr_q,
    output logic [DW-1:0]   rdata_q,
    output logic [DW-1:0]   tpsr_q,
    output logic [2*DW-1:0] tcnt_q,
    output logic [2*DW-1:0] rsar_q,
    output logic [2*DW-1:0] rcnt_q,
    output logic [DW-1:0]   rxcfg_q,
    output logic [DW-1:0]   dcfg_q,
    output logic            imr_we,
    output logic            isr_we
);
    localparam int IW      = PGW + AW;
    localparam int SPAN    = 1 << AW;
    // page 0
    localparam int IX_START = 1;
    localparam int IX_STOP  = 2;
    localparam int IX_BND   = 3;
    localparam int IX_TPSR  = 4;
    localparam int IX_TCL   = 5;
    localparam int IX_TCH   = 6;
    localparam int IX_ISR   = 7;
    localparam int IX_RSL   = 8;
    localparam int IX_RSH   = 9;
    localparam int IX_RCL   = 10;
    localparam int IX_RCH   = 11;
    localparam int IX_RXC   = 12;
    localparam int IX_DCF   = 14;
    localparam int IX_IMR   = 15;
    // page 1
    localparam int IX_PHYS0 = SPAN + 1;
    localparam int IX_CUR   = SPAN + 7;
    localparam int IX_MC0   = SPAN + 8;
    // page 2
    localparam int IX_START_RD = 2 * SPAN + 1;
    localparam int IX_STOP_RD  = 2 * SPAN + 2;

    logic [IW-1:0] idx;
    logic [DW-1:0] start_q, stop_q, bnd_q, cur_q;
    logic [DW-1:0] phys_q  [PHYS_N];
    logic [DW-1:0] mcast_q [MCAST_N];
    logic [DW-1:0] rd_val;

    assign idx    = {cmd_q[DW-1 -: PGW], off};
    assign imr_we = reg_we && (idx == IW'(IX_IMR));
    assign isr_we = reg_we && (idx == IW'(IX_ISR));

    // scalar and split-byte registers
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0; stop_q <= '0; bnd_q <= '0; cur_q <= '0;
            tpsr_q  <= '0; tcnt_q <= '0; rsar_q <= '0; rcnt_q <= '0;
            rxcfg_q <= '0; dcfg_q <= '0;
        end else if (reg_we) begin
            case (idx)
                IW'(IX_START): start_q          <= wdata;
                IW'(IX_STOP):  stop_q           <= wdata;
                IW'(IX_BND):   bnd_q            <= wdata;
                IW'(IX_TPSR):  tpsr_q           <= wdata;
                IW'(IX_TCL):   tcnt_q[DW-1:0]   <= wdata;
                IW'(IX_TCH):   tcnt_q[2*DW-1:DW] <= wdata;
                IW'(IX_RSL):   rsar_q[DW-1:0]   <= wdata;
                IW'(IX_RSH):   rsar_q[2*DW-1:DW] <= wdata;
                IW'(IX_RCL):   rcnt_q[DW-1:0]   <= wdata;
                IW'(IX_RCH):   rcnt_q[2*DW-1:DW] <= wdata;
                IW'(IX_RXC):   rxcfg_q          <= wdata;
                IW'(IX_DCF):   dcfg_q           <= wdata;
                IW'(IX_CUR):   cur_q            <= wdata;
                default: ;
            endcase
        end
    end

    // station address bytes
    for (genvar g = 0; g < PHYS_N; g++) begin : g_phys
        always_ff @(posedge clk) begin
            if (rst)                                     phys_q[g] <= '0;
            else if (reg_we && idx == IW'(IX_PHYS0 + g)) phys_q[g] <= wdata;
        end
    end

    // multicast filter bytes
    for (genvar g = 0; g < MCAST_N; g++) begin : g_mcast
        always_ff @(posedge clk) begin
            if (rst)                                   mcast_q[g] <= '0;
            else if (reg_we && idx == IW'(IX_MC0 + g)) mcast_q[g] <= wdata;
        end
    end

    // read view
    always_comb begin
        rd_val = '0;
        if (off == '0) begin
            rd_val = cmd_q;
        end else begin
            case (idx)
                IW'(IX_BND):      rd_val = bnd_q;
                IW'(IX_TPSR):     rd_val = tsr_q;
                IW'(IX_ISR):      rd_val = isr_q;
                IW'(IX_RSL):      rd_val = rsar_q[DW-1:0];
                IW'(IX_RSH):      rd_val = rsar_q[2*DW-1:DW];
                IW'(IX_RCL):      rd_val = ID_LO;
                IW'(IX_RCH):      rd_val = ID_HI;
                IW'(IX_CUR):      rd_val = cur_q;
                IW'(IX_START_RD): rd_val = start_q;
                IW'(IX_STOP_RD):  rd_val = stop_q;
                default:          rd_val = '0;
            endcase
            for (int i = 0; i < PHYS_N; i++)
                if (idx == IW'(IX_PHYS0 + i)) rd_val = phys_q[i];
            for (int i = 0; i < MCAST_N; i++)
                if (idx == IW'(IX_MC0 + i)) rd_val = mcast_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_re) rdata_q <= rd_val;
    end

endmodule

// File: rtl/nic_pagereg.sv
module nic_pagereg
    import nic_pagereg_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int PGW     = 2,
    parameter int PHYS_N  = 6,
    parameter int MCAST_N = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [DW-2:0]   stat_set,
    output logic            irq,
    output logic            tx_start,
    output logic [DW-1:0]   tx_page,
    output logic [2*DW-1:0] tx_count,
    output logic [1:0]      rdma_req,
    output logic [2*DW-1:0] rdma_addr,
    output logic [2*DW-1:0] rdma_count,
    output logic [DW-1:0]   rx_cfg,
    output logic [DW-1:0]   data_cfg
);
    logic            cmd_we, bank_we;
    logic [DW-1:0]   cmd_w, isr_w, tsr_w, tpsr_w;
    logic [2*DW-1:0] tcnt_w;
    logic            imr_we, isr_we;
    logic            clr_rst_bit, rdc_now, txok_now;
    logic [DW-2:0]   set_evt;

    assign cmd_we  = reg_wr && (reg_addr == '0);
    assign bank_we = reg_wr && (reg_addr != '0);

    always_comb begin
        set_evt = stat_set;
        if (txok_now) set_evt[SB_TXOK] = 1'b1;
        if (rdc_now)  set_evt[SB_RDC]  = 1'b1;
    end

    nic_cmd_ctl #(.DW(DW)) u_cmd (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .wdata(reg_wdata),
        .rcnt_zero(rdma_count == '0), .dma_done(stat_set[SB_RDC]),
        .tpsr(tpsr_w), .tcnt(tcnt_w), .cmd_q(cmd_w), .tsr_q(tsr_w),
        .clr_rst_bit(clr_rst_bit), .rdc_now(rdc_now), .txok_now(txok_now),
        .tx_fire_q(tx_start), .tx_page_q(tx_page), .tx_count_q(tx_count),
        .rdma_req(rdma_req)
    );

    nic_reg_bank #(.DW(DW), .AW(AW), .PGW(PGW), .PHYS_N(PHYS_N),
                   .MCAST_N(MCAST_N)) u_bank (
        .clk(clk), .rst(rst), .reg_we(bank_we), .reg_re(reg_rd),
        .off(reg_addr), .wdata(reg_wdata), .cmd_q(cmd_w), .isr_q(isr_w),
        .tsr_q(tsr_w), .rdata_q(reg_rdata), .tpsr_q(tpsr_w), .tcnt_q(tcnt_w),
        .rsar_q(rdma_addr), .rcnt_q(rdma_count), .rxcfg_q(rx_cfg),
        .dcfg_q(data_cfg), .imr_we(imr_we), .isr_we(isr_we)
    );

    nic_irq_unit #(.DW(DW)) u_irq (
        .clk(clk), .rst(rst), .isr_we(isr_we), .imr_we(imr_we),
        .wdata(reg_wdata[DW-2:0]), .clr_rst_bit(clr_rst_bit),
        .set_evt(set_evt), .isr_q(isr_w), .irq_o(irq)
    );

    // R9
    tx_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(reg_wr && reg_addr == '0 && reg_wdata[CB_TX]
                           && !reg_wdata[CB_STOP]));

    // R8
    zero_len_rdc_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !reg_wdata[CB_STOP] && (reg_wdata[CB_RRD] || reg_wdata[CB_RWR])
         && rdma_count == '0) |=> isr_w[SB_RDC]);

endmodule

// File: tb/nic_pagereg_tb.sv
`timescale 1ns/1ps
module nic_pagereg_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic [6:0]  stat_set = 0;
    logic        irq, tx_start;
    logic [7:0]  tx_page, rx_cfg, data_cfg;
    logic [15:0] tx_count, rdma_addr, rdma_count;
    logic [1:0]  rdma_req;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nic_pagereg u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_set(stat_set), .irq(irq), .tx_start(tx_start),
        .tx_page(tx_page), .tx_count(tx_count), .rdma_req(rdma_req),
        .rdma_addr(rdma_addr), .rdma_count(rdma_count),
        .rx_cfg(rx_cfg), .data_cfg(data_cfg)
    );

    // bench model of the banked map
    logic [7:0]  m_cmd, m_start, m_stop, m_bnd, m_tpsr, m_rxc, m_dcf, m_isr, m_tsr, m_cur;
    logic [15:0] m_tcnt, m_rsar, m_rcnt;
    logic [7:0]  m_phys [6];
    logic [7:0]  m_mc   [8];

    function automatic logic [7:0] exp_rd(input logic [3:0] off);
        logic [5:0] ix;
        ix = {m_cmd[7:6], off};
        if (off == 0) return m_cmd;
        if (ix >= 6'h11 && ix <= 6'h16) return m_phys[ix - 6'h11];
        if (ix >= 6'h18 && ix <= 6'h1F) return m_mc[ix - 6'h18];
        case (ix)
            6'h03: return m_bnd;
            6'h04: return m_tsr;
            6'h07: return m_isr;
            6'h08: return m_rsar[7:0];
            6'h09: return m_rsar[15:8];
            6'h0A: return 8'h50;
            6'h0B: return 8'h43;
            6'h17: return m_cur;
            6'h21: return m_start;
            6'h22: return m_stop;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_wr(input logic [3:0] off, input logic [7:0] d);
        logic [5:0] ix;
        ix = {m_cmd[7:6], off};
        if (off == 0) m_cmd = d;
        else if (ix >= 6'h11 && ix <= 6'h16) m_phys[ix - 6'h11] = d;
        else if (ix >= 6'h18 && ix <= 6'h1F) m_mc[ix - 6'h18] = d;
        else case (ix)
            6'h01: m_start = d;
            6'h02: m_stop = d;
            6'h03: m_bnd = d;
            6'h04: m_tpsr = d;
            6'h05: m_tcnt[7:0] = d;
            6'h06: m_tcnt[15:8] = d;
            6'h08: m_rsar[7:0] = d;
            6'h09: m_rsar[15:8] = d;
            6'h0A: m_rcnt[7:0] = d;
            6'h0B: m_rcnt[15:8] = d;
            6'h0C: m_rxc = d;
            6'h0E: m_dcf = d;
            6'h17: m_cur = d;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [1:0] pg, input logic [3:0] off);
        if (off == 0 || pg == 1) return "R2";
        if (pg == 2) return (off == 1 || off == 2) ? "R3" : "R4";
        if (pg == 3) return "R4";
        if (off == 1 || off == 2 || off == 3 || off == 8 || off == 9 || off == 10 || off == 11) return "R3";
        if (off == 4 || off == 7) return "R2";
        return "R4";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_set(input logic [3:0] a, input logic [7:0] d, input logic [6:0] s);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d; stat_set = s;
        @(negedge clk);
        reg_wr = 0; stat_set = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_set(a, d, 7'h00);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    task automatic pset(input logic [6:0] s);
        @(negedge clk);
        stat_set = s;
        @(negedge clk);
        stat_set = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        m_cmd = 8'h21; m_start = 0; m_stop = 0; m_bnd = 0; m_tpsr = 0; m_rxc = 0;
        m_dcf = 0; m_isr = 8'h80; m_tsr = 0; m_cur = 0; m_tcnt = 0; m_rsar = 0; m_rcnt = 0;
        for (int i = 0; i < 6; i++) m_phys[i] = 0;
        for (int i = 0; i < 8; i++) m_mc[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 tx_start", tx_start, 0);
        chk("R1 rdma_req", rdma_req, 0);
        rd(4'd7, v); chk("R1 status", v, 8'h80);
        rd(4'd0, v); chk("R1 command", v, 8'h21);

        // R2 R3 R4 R11 random banked accesses, stop bit kept set
        for (int i = 0; i < 400; i++) begin
            logic [1:0] pg, rp;
            logic [3:0] off, roff;
            logic [7:0] d;
            pg = 2'($urandom_range(0, 3));
            off = 4'($urandom_range(1, 15));
            d = 8'($urandom);
            if (!(pg == 0 && (off == 7 || off == 15))) begin
                wr(4'd0, {pg, 6'h21}); model_wr(4'd0, {pg, 6'h21});
                wr(off, d); model_wr(off, d);
            end
            rp = 2'($urandom_range(0, 3));
            roff = 4'($urandom_range(0, 15));
            wr(4'd0, {rp, 6'h21}); model_wr(4'd0, {rp, 6'h21});
            rd(roff, v);
            chk($sformatf("%s read p%0d o%0d", tag_of(rp, roff), rp, roff), v, exp_rd(roff));
            if (i % 50 == 0) begin
                chk("R11 rx_cfg", rx_cfg, m_rxc);
                chk("R11 data_cfg", data_cfg, m_dcf);
                chk("R11 rdma_addr", rdma_addr, m_rsar);
            end
        end

        // R2 page-1 byte does not disturb page-0 boundary at same offset
        wr(4'd0, 8'h21); wr(4'd3, 8'h5A);
        wr(4'd0, 8'h61); wr(4'd3, 8'hA5);
        rd(4'd3, v); chk("R2 page1 phys byte", v, 8'hA5);
        wr(4'd0, 8'h21);
        rd(4'd3, v); chk("R2 page0 boundary kept", v, 8'h5A);

        // R5 R6 reset bit never interrupts and ignores clears
        wr(4'd15, 8'hFF);
        chk("R5 bit7 no irq", irq, 0);
        wr(4'd7, 8'h80);
        rd(4'd7, v); chk("R6 bit7 unaffected", v, 8'h80);

        // R7 start clears reset bit
        wr(4'd0, 8'h22);
        rd(4'd7, v); chk("R7 reset bit cleared", v, 8'h00);

        // R5 R6 set, clear, mask
        wr(4'd15, 8'h7F);
        pset(7'h05);
        rd(4'd7, v); chk("R6 event set", v, 8'h05);
        chk("R5 irq high", irq, 1);
        wr(4'd7, 8'h01);
        rd(4'd7, v); chk("R6 partial clear", v, 8'h04);
        chk("R5 irq still high", irq, 1);
        wr(4'd7, 8'h04);
        chk("R5 irq low", irq, 0);
        wr(4'd15, 8'h00);
        pset(7'h10);
        chk("R5 masked", irq, 0);
        wr(4'd15, 8'h10);
        chk("R5 unmasked", irq, 1);
        wr_set(4'd7, 8'h10, 7'h10);
        rd(4'd7, v); chk("R6 set wins", v, 8'h10);
        wr(4'd7, 8'h7F);
        rd(4'd7, v); chk("R6 clear all", v, 8'h00);

        // R3 ID bytes versus remote count
        wr(4'd10, 8'h12); wr(4'd11, 8'h34);
        rd(4'd10, v); chk("R3 id lo", v, 8'h50);
        rd(4'd11, v); chk("R3 id hi", v, 8'h43);
        chk("R11 rdma_count", rdma_count, 16'h3412);
        wr(4'd8, 8'hCD); wr(4'd9, 8'hAB);
        chk("R11 rdma_addr", rdma_addr, 16'hABCD);
        rd(4'd8, v); chk("R3 rsar lo", v, 8'hCD);

        // R8 zero-length remote DMA
        wr(4'd10, 8'h00); wr(4'd11, 8'h00);
        wr(4'd0, 8'h0A);
        rd(4'd7, v); chk("R8 zero len rdc", v, 8'h40);
        chk("R10 no rdma on zero", rdma_req, 2'b00);
        wr(4'd7, 8'h40);
        wr(4'd10, 8'h05);
        wr(4'd0, 8'h12);
        chk("R10 rdma write", rdma_req, 2'b10);
        rd(4'd7, v); chk("R8 nonzero no rdc", v, 8'h00);
        pset(7'h40);
        chk("R10 done exit", rdma_req, 2'b00);
        rd(4'd7, v); chk("R6 done event", v, 8'h40);
        wr(4'd7, 8'h40);
        wr(4'd0, 8'h0A);
        chk("R10 rdma read", rdma_req, 2'b01);
        wr(4'd0, 8'h22);
        chk("R10 command exit", rdma_req, 2'b00);
        wr(4'd0, 8'h12);
        wr(4'd0, 8'h21);
        chk("R10 stop exit", rdma_req, 2'b00);
        rd(4'd0, v); chk("R10 stopped cmd", v, 8'h21);

        // R9 transmit
        wr(4'd4, 8'h40); wr(4'd5, 8'hEA); wr(4'd6, 8'h05);
        wr(4'd0, 8'h26);
        chk("R9 tx pulse", tx_start, 1);
        chk("R9 tx page", tx_page, 8'h40);
        chk("R9 tx count", tx_count, 16'h05EA);
        @(negedge clk);
        chk("R9 pulse one cycle", tx_start, 0);
        rd(4'd0, v); chk("R9 tx bit cleared", v, 8'h22);
        rd(4'd4, v); chk("R9 tx status", v, 8'h01);
        rd(4'd7, v); chk("R9 status bit1", v & 8'h02, 8'h02);
        wr(4'd0, 8'h25);
        chk("R9 no tx when stopped", tx_start, 0);
        @(negedge clk);
        chk("R9 no tx later", tx_start, 0);
        rd(4'd0, v); chk("R9 stopped cmd kept", v, 8'h25);

        // R11 configuration outputs
        wr(4'd0, 8'h21);
        wr(4'd12, 8'h1C); wr(4'd14, 8'h49);
        chk("R11 rx_cfg", rx_cfg, 8'h1C);
        chk("R11 data_cfg", data_cfg, 8'h49);

        // R4 page 3 reads zero
        wr(4'd0, 8'hE1);
        rd(4'd3, v); chk("R4 page3", v, 8'h00);

        summary();
    end
endmodule